// File: doc/BRIEF.md
# Byte-to-Word Disk Port Bridge

This block sits between an 8-bit CPU I/O bus and the 16-bit command block of a disk drive. It decodes eight drive registers from the low address byte and drives a 3-bit register select with read and write strobes toward the drive. Seven of the registers are eight bits wide and pass their data straight through. The eighth, the data register, is sixteen bits wide. The bridge splits each word read from it into two CPU bytes, and it joins two CPU bytes into each word written to it.

The data register works with a two-phase toggle. In the first (odd) access of a pair the drive is read, or the write byte is captured. In the second (even) access the stored byte is returned, or the full word is written. The phase returns to odd when the CPU touches any other port in the bridge's group: one of the seven narrow drive registers, or the control port at E3h. Traffic to any other I/O address leaves the phase alone. CPU accesses are single-cycle strobes that are synchronous to `clk`. The drive strobes and the CPU read data are combinational within the access cycle. The phase and the stored byte update at the clock edge that ends the access.

Top module: `disk_port_bridge`

## Requirements
- R1: A drive register is hit when `(cpu_addr & E3h) == A3h`, which gives addresses A3h, A7h, ABh, AFh, B3h, B7h, BBh and BFh. `drv_sel` carries `cpu_addr[4:2]`, and index 0 (A3h) is the data register. For any other address there is no drive strobe and `cpu_rdata` is 00h.
- R2: An odd-phase read of the data register raises `drv_rd` in the same cycle and returns `drv_rdata[7:0]` on `cpu_rdata`. It also stores `drv_rdata[15:8]`.
- R3: An even-phase read of the data register returns the stored byte and leaves `drv_rd` low.
- R4: An odd-phase write of the data register stores `cpu_wdata` and leaves `drv_wr` low.
- R5: An even-phase write of the data register raises `drv_wr` with `drv_wdata = {cpu_wdata, stored byte}`.
- R6: Each data-register access flips the phase exactly once, at the clock edge that ends it.
- R7: An access to a narrow drive register (index 1 to 7) or to the control port E3h makes the next data access odd.
- R8: An access to an address outside the group leaves the phase unchanged.
- R9: A narrow drive register read raises `drv_rd` and returns `drv_rdata[7:0]`. A narrow drive register write raises `drv_wr` with `drv_wdata = {00h, cpu_wdata}`.
- R10: Reset puts the phase at odd and clears the stored byte. While reset is applied, no drive strobe is raised.
- R11: A cycle with `cpu_rd` and `cpu_wr` both high is not an access: there is no drive strobe, `cpu_rdata` is 00h and the phase is unchanged.
- R12: Read and write share one stored byte. An even write after an odd read uses the high byte from that read as the low half of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Low byte of the CPU I/O address |
| cpu_rd | input | 1 | CPU I/O read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU I/O write strobe, one cycle per access |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte returned to the CPU |
| drv_rdata | input | 16 | Word read from the drive |
| drv_sel | output | 3 | Drive register index |
| drv_rd | output | 1 | Drive read strobe |
| drv_wr | output | 1 | Drive write strobe |
| drv_wdata | output | 16 | Word written to the drive |

## Verification
The assertions check the following on every cycle:
- The phase moves as required for data, in-group and foreign accesses.
- The even read stays local and the odd write stays silent.
- The two drive strobes are never high together.
- Narrow writes carry a zero upper byte.
- Foreign addresses stay quiet.

Only the bench scenarios show the byte values themselves:
- The order in which the two halves are assembled across a pair.
- The shared stored byte crossing from a read into a write.
- The return to odd after reset released in the middle of a pair.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic {
    PH_ODD  = 1'b0,
    PH_EVEN = 1'b1
  } phase_e;

  typedef struct packed {
    logic drv;   // any drive register in the group
    logic data;  // the wide data register
    logic ctrl;  // the control port
  } hit_t;
endpackage

// File: rtl/dpb_rst_sync.sv
module dpb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dpb_decode.sv
module dpb_decode
  import dpb_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              IDX_W       = 3,
  parameter int              IDX_LSB     = 2,
  parameter logic [ADDR_W-1:0] GROUP_MASK  = 8'hE3,
  parameter logic [ADDR_W-1:0] GROUP_MATCH = 8'hA3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'hE3,
  parameter logic [IDX_W-1:0]  DATA_IDX    = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit,
  output logic [IDX_W-1:0]  idx
);
  logic in_drv;

  always_comb begin
    idx      = addr[IDX_LSB +: IDX_W];
    in_drv   = ((addr & GROUP_MASK) == GROUP_MATCH);
    hit.drv  = in_drv;
    hit.data = in_drv && (idx == DATA_IDX);
    hit.ctrl = (addr == CTRL_ADDR);
  end
endmodule

// File: rtl/dpb_phase.sv
module dpb_phase
  import dpb_pkg::*;
#(
  parameter int CPU_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  hit_t             hit,
  input  logic [CPU_W-1:0] drv_hi,
  input  logic [CPU_W-1:0] cpu_wdata,
  output phase_e           phase,
  output logic [CPU_W-1:0] hold
);
  phase_e           phase_q, phase_d;
  logic [CPU_W-1:0] hold_q, hold_d;
  logic             hold_en;
  logic             acc;

  assign acc = acc_rd || acc_wr;

  always_comb begin
    phase_d = phase_q;
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (acc && hit.data) begin
      phase_d = (phase_q == PH_ODD) ? PH_EVEN : PH_ODD;
      if (phase_q == PH_ODD) begin
        hold_en = 1'b1;
        hold_d  = acc_rd ? drv_hi : cpu_wdata;
      end
    end else if (acc && (hit.drv || hit.ctrl)) begin
      phase_d = PH_ODD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ODD;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign phase = phase_q;
  assign hold  = hold_q;

  AST_DATA_ACCESS_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit.data) |=> (phase != $past(phase)));  // R6
  AST_GROUP_FORCES_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit.data && (hit.drv || hit.ctrl)) |=> (phase == PH_ODD));  // R7
  AST_FOREIGN_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc || !(hit.drv || hit.ctrl)) |=> $stable(phase));  // R8
endmodule

// File: rtl/dpb_datapath.sv
module dpb_datapath
  import dpb_pkg::*;
#(
  parameter int CPU_W = 8,
  parameter int IDX_W = 3
) (
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  hit_t               hit,
  input  logic [IDX_W-1:0]   idx,
  input  phase_e             phase,
  input  logic [CPU_W-1:0]   hold,
  input  logic [CPU_W-1:0]   cpu_wdata,
  input  logic [2*CPU_W-1:0] drv_rdata,
  output logic [CPU_W-1:0]   cpu_rdata,
  output logic [IDX_W-1:0]   drv_sel,
  output logic               drv_rd,
  output logic               drv_wr,
  output logic [2*CPU_W-1:0] drv_wdata
);
  localparam int DRV_W = 2 * CPU_W;

  logic narrow;

  always_comb begin
    narrow  = hit.drv && !hit.data;
    drv_sel = idx;
    drv_rd  = acc_rd && (narrow || (hit.data && phase == PH_ODD));
    drv_wr  = acc_wr && (narrow || (hit.data && phase == PH_EVEN));
    if (hit.data) drv_wdata = {cpu_wdata, hold};
    else          drv_wdata = {{(DRV_W-CPU_W){1'b0}}, cpu_wdata};
    cpu_rdata = '0;
    if (acc_rd && hit.drv) begin
      if (hit.data && phase == PH_EVEN) cpu_rdata = hold;
      else                              cpu_rdata = drv_rdata[CPU_W-1:0];
    end
  end
endmodule

// File: rtl/disk_port_bridge.sv
module disk_port_bridge
  import dpb_pkg::*;
#(
  parameter int CPU_W   = 8,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 3,
  parameter int IDX_LSB = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] GROUP_MASK  = 8'hE3,
  parameter logic [ADDR_W-1:0] GROUP_MATCH = 8'hA3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'hE3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [CPU_W-1:0]     cpu_wdata,
  output logic [CPU_W-1:0]     cpu_rdata,
  input  logic [2*CPU_W-1:0]   drv_rdata,
  output logic [IDX_W-1:0]     drv_sel,
  output logic                 drv_rd,
  output logic                 drv_wr,
  output logic [2*CPU_W-1:0]   drv_wdata
);
  localparam int DRV_W = 2 * CPU_W;

  logic             rst_sync_n;
  logic             acc_rd, acc_wr;
  hit_t             hit;
  logic [IDX_W-1:0] idx;
  phase_e           phase;
  logic [CPU_W-1:0] hold;

  // a cycle with both strobes high is not an access
  assign acc_rd = cpu_rd && !cpu_wr && rst_sync_n;
  assign acc_wr = cpu_wr && !cpu_rd && rst_sync_n;

  dpb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  dpb_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB),
    .GROUP_MASK(GROUP_MASK), .GROUP_MATCH(GROUP_MATCH),
    .CTRL_ADDR(CTRL_ADDR), .DATA_IDX('0)
  ) u_dec (.addr(cpu_addr), .hit(hit), .idx(idx));

  dpb_phase #(.CPU_W(CPU_W)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .hit(hit), .drv_hi(drv_rdata[DRV_W-1:CPU_W]), .cpu_wdata(cpu_wdata),
    .phase(phase), .hold(hold));

  dpb_datapath #(.CPU_W(CPU_W), .IDX_W(IDX_W)) u_dp (
    .acc_rd(acc_rd), .acc_wr(acc_wr), .hit(hit), .idx(idx),
    .phase(phase), .hold(hold), .cpu_wdata(cpu_wdata),
    .drv_rdata(drv_rdata), .cpu_rdata(cpu_rdata), .drv_sel(drv_sel),
    .drv_rd(drv_rd), .drv_wr(drv_wr), .drv_wdata(drv_wdata));

  AST_EVEN_READ_LOCAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_rd && hit.data && phase == PH_EVEN) |-> (!drv_rd && cpu_rdata == hold));  // R3
  AST_ODD_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_wr && hit.data && phase == PH_ODD) |-> !drv_wr);  // R4
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({drv_rd, drv_wr}));  // R11
  AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (drv_wr && drv_sel != '0) |-> (drv_wdata[DRV_W-1:CPU_W] == '0));  // R9
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit.drv |-> (!drv_rd && !drv_wr && cpu_rdata == '0));  // R1
endmodule

// File: tb/disk_port_bridge_test.sv
module disk_port_bridge_test;
  typedef struct packed {
    logic [7:0]  addr;
    logic        rd;
    logic        wr;
    logic [7:0]  wd;
    logic [15:0] dr;
    logic [7:0]  er;
    logic        edrd;
    logic        edwr;
    logic [15:0] ew;
    logic [2:0]  esel;
    logic [3:0]  req;
  } vec_t;

  localparam int N = 23;
  localparam vec_t TBL [0:N-1] = '{
    '{8'hA3,1'b1,1'b0,8'h00,16'h1234,8'h34,1'b1,1'b0,16'h0000,3'd0,4'd2},  // R2 odd read
    '{8'hA3,1'b1,1'b0,8'h00,16'hFFFF,8'h12,1'b0,1'b0,16'h0000,3'd0,4'd3},  // R3 even read
    '{8'hA3,1'b0,1'b1,8'hCD,16'h0000,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd4},  // R4 odd write
    '{8'hA3,1'b0,1'b1,8'hAB,16'h0000,8'h00,1'b0,1'b1,16'hABCD,3'd0,4'd5},  // R5 even write
    '{8'hA3,1'b1,1'b0,8'h00,16'h5678,8'h78,1'b1,1'b0,16'h0000,3'd0,4'd6},  // R6 odd again
    '{8'hAB,1'b1,1'b0,8'h00,16'h9911,8'h11,1'b1,1'b0,16'h0000,3'd2,4'd9},  // R9 narrow read
    '{8'hA3,1'b0,1'b1,8'h22,16'h0000,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd7},  // R7 odd after narrow
    '{8'hE3,1'b0,1'b1,8'h00,16'h0000,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd7},  // R7 control port
    '{8'hA3,1'b0,1'b1,8'h33,16'h0000,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd7},  // R7 odd after control
    '{8'h1F,1'b1,1'b0,8'h00,16'hAAAA,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd8},  // R8 foreign read
    '{8'hA3,1'b0,1'b1,8'h44,16'h0000,8'h00,1'b0,1'b1,16'h4433,3'd0,4'd8},  // R8 even kept
    '{8'hBF,1'b0,1'b1,8'hEC,16'h0000,8'h00,1'b0,1'b1,16'h00EC,3'd7,4'd9},  // R9 narrow write
    '{8'hB7,1'b1,1'b0,8'h00,16'hBEEF,8'hEF,1'b1,1'b0,16'h0000,3'd5,4'd9},  // R9 narrow read
    '{8'hA3,1'b1,1'b0,8'h00,16'h0102,8'h02,1'b1,1'b0,16'h0000,3'd0,4'd6},  // R6
    '{8'hA7,1'b0,1'b1,8'h5A,16'h0000,8'h00,1'b0,1'b1,16'h005A,3'd1,4'd7},  // R7 mid-pair
    '{8'hA3,1'b1,1'b0,8'h00,16'h0A0B,8'h0B,1'b1,1'b0,16'h0000,3'd0,4'd7},  // R7 odd read
    '{8'hA3,1'b0,1'b1,8'h0C,16'h0000,8'h00,1'b0,1'b1,16'h0C0A,3'd0,4'd12}, // R12 shared byte
    '{8'hA2,1'b1,1'b0,8'h00,16'h1111,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd1},  // R1 near miss
    '{8'hE7,1'b1,1'b0,8'h00,16'h2222,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd1},  // R1 outside group
    '{8'hA3,1'b1,1'b1,8'h77,16'h3333,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd11}, // R11 both strobes
    '{8'hA3,1'b0,1'b1,8'h88,16'h0000,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd11}, // R11 still odd
    '{8'h63,1'b0,1'b1,8'h55,16'h0000,8'h00,1'b0,1'b0,16'h0000,3'd0,4'd1},  // R1 bit7 clear
    '{8'hA3,1'b0,1'b1,8'h99,16'h0000,8'h00,1'b0,1'b1,16'h9988,3'd0,4'd8}   // R8 even kept
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cpu_addr = 8'h00;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [15:0] drv_rdata = 16'h0000;
  logic [2:0]  drv_sel;
  logic        drv_rd, drv_wr;
  logic [15:0] drv_wdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  disk_port_bridge uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .drv_rdata(drv_rdata), .drv_sel(drv_sel), .drv_rd(drv_rd),
    .drv_wr(drv_wr), .drv_wdata(drv_wdata));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic r, input logic w,
                       input logic [7:0] wd, input logic [15:0] dr);
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_wdata = wd; drv_rdata = dr;
    #1;
  endtask

  task automatic idle();
    drive(8'h00, 1'b0, 1'b0, 8'h00, 16'h0000);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: idle outputs while reset is held
    repeat (3) @(negedge clk);
    #1;
    chk(!drv_rd && !drv_wr && cpu_rdata == 8'h00, "R10", "strobes in reset",
        {drv_rd, drv_wr, 6'd0, cpu_rdata}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) idle();

    for (int i = 0; i < N; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].req, i);
      drive(TBL[i].addr, TBL[i].rd, TBL[i].wr, TBL[i].wd, TBL[i].dr);
      chk(cpu_rdata == TBL[i].er, tag, "cpu_rdata", {8'h00, cpu_rdata}, {8'h00, TBL[i].er});
      chk(drv_rd == TBL[i].edrd, tag, "drv_rd", {15'd0, drv_rd}, {15'd0, TBL[i].edrd});
      chk(drv_wr == TBL[i].edwr, tag, "drv_wr", {15'd0, drv_wr}, {15'd0, TBL[i].edwr});
      if (TBL[i].edwr)
        chk(drv_wdata == TBL[i].ew, tag, "drv_wdata", drv_wdata, TBL[i].ew);
      if (TBL[i].edrd || TBL[i].edwr)
        chk(drv_sel == TBL[i].esel, tag, "drv_sel", {13'd0, drv_sel}, {13'd0, TBL[i].esel});
    end
    idle();

    // R10: reset in the middle of a pair returns the phase to odd
    drive(8'hA3, 1'b1, 1'b0, 8'h00, 16'h6655);
    chk(drv_rd && cpu_rdata == 8'h55, "R10", "odd read before reset",
        {7'd0, drv_rd, cpu_rdata}, 16'h0155);
    idle();
    rst_n = 1'b0;
    repeat (2) idle();
    chk(!drv_rd && !drv_wr, "R10", "strobes during reset",
        {14'd0, drv_rd, drv_wr}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) idle();
    drive(8'hA3, 1'b0, 1'b1, 8'h11, 16'h0000);
    chk(!drv_wr, "R10", "first write after reset is odd", {15'd0, drv_wr}, 16'h0000);
    drive(8'hA3, 1'b0, 1'b1, 8'h22, 16'h0000);
    chk(drv_wr && drv_wdata == 16'h2211, "R10", "pair after reset", drv_wdata, 16'h2211);
    idle();

    // R6: idle cycles between the halves of a pair do not move the phase
    drive(8'hA3, 1'b1, 1'b0, 8'h00, 16'h7F80);
    repeat (3) idle();
    drive(8'hA3, 1'b1, 1'b0, 8'h00, 16'h0000);
    chk(!drv_rd && cpu_rdata == 8'h7F, "R6", "even read after idle gap",
        {7'd0, drv_rd, cpu_rdata}, 16'h007F);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule